// File: doc/BRIEF.md
# Short-Pulse Catching Synchronizer

This block brings a single-bit asynchronous event into a destination clock domain. The event may be narrower than one destination clock period. The rising edge of the raw input clocks a capture flop that stores a constant one. A short pulse therefore leaves a mark even if no destination clock edge falls inside it. The marked flag then passes through two destination-clocked flops. The second flop gives the first one a full period to recover from metastability before its value is used.

The synchronized output clears the capture flag asynchronously. This clear is held off while the raw input is still high, so a long pulse cannot re-arm the flag or cut off its own event.

A parameter selects between this pulse-catching form and a plain two-flop chain. The plain chain is only safe when every input pulse lasts at least one destination period.

Top module: `pulse_catch_sync`

## Requirements
- R1: While `rst` is high, `evt_sync` is low and the capture flag is cleared. A pulse on `evt_in` during reset produces no output after reset is released.
- R2: With `CATCH_SHORT`=1, a rising edge on `evt_in` sets the output high at the second rising edge of `clk_dst` after the input edge. The output is still low after the first such edge.
- R3: With `CATCH_SHORT`=1, each isolated input pulse gives exactly one rising edge on `evt_sync`, whatever its width or phase.
- R4: With `CATCH_SHORT`=1, a pulse that has ended before the output rises keeps `evt_sync` high for exactly two destination cycles.
- R5: With `CATCH_SHORT`=1, the output stays high while the input is held high. It falls at the second `clk_dst` rising edge after the input falls.
- R6: With `CATCH_SHORT`=1, every output assertion lasts at least two destination cycles.
- R7: With `CATCH_SHORT`=0, the input feeds the two-flop chain directly. The output is high for as many cycles as there are `clk_dst` rising edges during the pulse, so a pulse that spans no edge is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_dst | input | 1 | Destination domain clock |
| rst | input | 1 | Active-high asynchronous reset |
| evt_in | input | 1 | Asynchronous event input |
| evt_sync | output | 1 | Event level synchronized to `clk_dst` |

## Verification
Two functions meet in the capture flop. The synchronized output asks for the clear, and the raw input, still high, must hold that clear off. Pulses longer than two destination periods make the output rise while the input is high.

These cases are judged by counting high cycles at the falling clock edge. The count is compared with the number of edges up to the second one after the input falls, and exactly one output rise per pulse is required. The same pulses, at random phases, also drive the plain-chain variant, which is checked against the edges each pulse spans.

// File: rtl/pulse_catch_sync.sv
module pulse_catch_sync #(
  parameter bit CATCH_SHORT = 1'b1
) (
  input  logic clk_dst,
  input  logic rst,
  input  logic evt_in,
  output logic evt_sync
);

  logic cap_q;
  logic chain_d;
  logic meta_q;
  logic sync_q;

  generate
    if (CATCH_SHORT) begin : g_catch
      logic cap_clr;
      assign cap_clr = rst | (sync_q & ~evt_in);

      always_ff @(posedge evt_in or posedge cap_clr) begin
        if (cap_clr) cap_q <= 1'b0;
        else         cap_q <= 1'b1;
      end

      assign chain_d = cap_q;
    end else begin : g_plain
      assign cap_q   = 1'b0;
      assign chain_d = evt_in;
    end
  endgenerate

  always_ff @(posedge clk_dst or posedge rst) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= chain_d;
      sync_q <= meta_q;
    end
  end

  assign evt_sync = sync_q;

endmodule

// File: rtl/pulse_catch_sync_chk.sv
module pulse_catch_sync_chk #(
  parameter bit CATCH = 1'b1
) (
  input logic clk_dst,
  input logic rst,
  input logic evt_in,
  input logic cap_q,
  input logic evt_sync
);

  // R1
  always @(negedge clk_dst) begin
    if (rst) begin
      reset_chk: assert (!evt_sync && !cap_q);
    end
  end

  // R2
  latency_chk: assert property (@(posedge clk_dst) disable iff (rst)
    (CATCH && $rose(evt_sync)) |-> $past(cap_q));

  // R6
  min_high_chk: assert property (@(posedge clk_dst) disable iff (rst)
    (CATCH && $rose(evt_sync)) |=> evt_sync);

  // R5
  hold_off_chk: assert property (@(posedge clk_dst) disable iff (rst)
    (CATCH && $past(cap_q) && $past(evt_in) && evt_in) |-> cap_q);

endmodule

bind pulse_catch_sync pulse_catch_sync_chk #(.CATCH(CATCH_SHORT)) u_chk (
  .clk_dst  (clk_dst),
  .rst      (rst),
  .evt_in   (evt_in),
  .cap_q    (cap_q),
  .evt_sync (evt_sync)
);

// File: tb/pulse_catch_sync_bench.sv
`timescale 1ps/1ps
module pulse_catch_sync_bench;

  localparam int PER = 4000;
  localparam int N_VEC = 8;
  localparam int VOFF [N_VEC] = '{500, 3500, 1000, 200, 1500, 2000, 700, 3000};
  localparam int VWID [N_VEC] = '{300, 400, 2500, 3000, 4200, 9000, 15000, 18500};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic evt = 1'b0;
  logic out_c, out_b;

  int total = 0;
  int bad = 0;
  int rise_c, high_c, rise_b, high_b;
  bit prev_c, prev_b;

  always #(PER/2) clk = ~clk;

  pulse_catch_sync #(.CATCH_SHORT(1'b1)) u_pulse_catch_sync (
    .clk_dst(clk), .rst(rst), .evt_in(evt), .evt_sync(out_c));

  pulse_catch_sync #(.CATCH_SHORT(1'b0)) u_plain (
    .clk_dst(clk), .rst(rst), .evt_in(evt), .evt_sync(out_b));

  always @(negedge clk) begin
    if (out_c && !prev_c) rise_c++;
    if (out_c) high_c++;
    if (out_b && !prev_b) rise_b++;
    if (out_b) high_b++;
    prev_c = out_c;
    prev_b = out_b;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    rise_c = 0; high_c = 0; rise_b = 0; high_b = 0;
  endtask

  function automatic int exp_high_c(input int off, input int w);
    int j;
    j = (off + w) / PER + 1;
    return (j - 1 < 2) ? 2 : j - 1;
  endfunction

  task automatic run_pulse(input int off, input int w);
    int eh_c, eh_b;
    eh_c = exp_high_c(off, w);
    eh_b = (off + w) / PER;
    @(posedge clk);
    clear_counts();
    #(off);
    fork
      begin
        evt = 1'b1;
        #(w);
        evt = 1'b0;
      end
      begin
        @(posedge clk); #(PER/2);
        chk(out_c == 1'b0, "R2 low after first edge", out_c, 0);
        @(posedge clk); #(PER/2);
        chk(out_c == 1'b1, "R2 high after second edge", out_c, 1);
      end
    join
    repeat (10) @(posedge clk);
    #(PER/4);
    chk(rise_c == 1, "R3 one rise per pulse", rise_c, 1);
    if (off + w < 2 * PER)
      chk(high_c == 2, "R4 narrow pulse high cycles", high_c, 2);
    else
      chk(high_c == eh_c, "R5 held-high cycles", high_c, eh_c);
    chk(high_c >= 2, "R6 minimum high", high_c, 2);
    chk(high_b == eh_b, "R7 plain chain high cycles", high_b, eh_b);
    chk(rise_b == ((eh_b > 0) ? 1 : 0), "R7 plain chain rises", rise_b, (eh_b > 0) ? 1 : 0);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * PER);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    clear_counts();
    #100 rst = 1'b1;
    @(negedge clk);
    chk(out_c == 1'b0, "R1 reset output catch", out_c, 0);
    chk(out_b == 1'b0, "R1 reset output plain", out_b, 0);
    @(posedge clk); #700;
    evt = 1'b1; #300; evt = 1'b0;
    @(negedge clk);
    chk(out_c == 1'b0, "R1 pulse during reset", out_c, 0);
    @(posedge clk); #1000;
    rst = 1'b0;
    clear_counts();
    repeat (6) @(posedge clk);
    #(PER/4);
    chk(rise_c == 0, "R1 no event after reset release", rise_c, 0);

    for (int i = 0; i < N_VEC; i++)
      run_pulse(VOFF[i], VWID[i]);

    for (int i = 0; i < 8; i++) begin
      int off, w, m;
      off = $urandom_range(3700, 300);
      w = $urandom_range(20000, 200);
      m = (off + w) % PER;
      if (m < 300 || m > 3700) w += 600;
      run_pulse(off, w);
    end

    run_pulse(1900, 150);
    run_pulse(2100, 3 * PER + 1000);

    finish_up();
  end

endmodule